// File: doc/BRIEF.md
# USB Host Port Suspend, Resume and Reset Controller

This block holds the control and status bits of one USB host port: power, enable, suspend, resume and reset, plus a sticky change flag. Software updates all of them with a single-cycle write strobe that carries a 6-bit field word. The block times the bus reset and the resume signaling itself. Each of those bits clears itself when its sequence ends, so software never has to time either duration.

A suspend request made during a bus transaction is held until the transaction ends. While the port is suspended, a J-to-K transition on the sampled line state counts as a remote wakeup. It starts resume signaling and raises the change flag. The durations are parameters counted in clock cycles.

Top module: `usbp_port_ctrl`

## Requirements
- R1: After reset every output is 0 and `port_state` reads 2'b00 (disabled).
- R2: A write with bit 4 set, while the port is powered and not already in reset, sets `prst_o` and `drive_se0` for exactly RESET_CYC cycles, after which both clear on their own. Starting a reset clears suspend, pending suspend and resume.
- R3: Every write loads power from bit 0 and enable from bit 1. `port_state` is 2'b00 when power or enable is 0, 2'b01 when enabled and not suspended, and 2'b10 when enabled and suspended. `tx_allow` is 1 only in state 2'b01 with no reset running.
- R4: A write with bit 2 set on an enabled, idle port sets `susp_o` in the next cycle. If `xact_busy` is 1 at the write, `susp_o` stays 0 until the cycle after `xact_busy` is seen at 0.
- R5: Writing 0 to bit 2 (suspend) or bit 3 (resume) leaves `susp_o` and `fres_o` unchanged.
- R6: A suspend write made while the written enable (bit 1) is 0 changes neither `susp_o` nor `port_state`.
- R7: While suspended, a sampled `line_state` of 2'b01 (J) followed by 2'b10 (K) in the next cycle sets `fres_o` and `chg_o` one cycle after K is sampled. The same transition has no effect when the port is not suspended.
- R8: A write with bit 3 set on an enabled port sets `fres_o` and `drive_k` for exactly RESUME_CYC cycles. Remote wakeup resume lasts the same time. `susp_o` clears in the same cycle that `fres_o` clears.
- R9: `chg_o` stays set until a write with bit 5 set clears it.
- R10: While power is 0, `prst_o`, `susp_o` and `fres_o` read 0, and writes that try to set them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 6 | Write fields: 0 power, 1 enable, 2 suspend, 3 resume, 4 reset, 5 change clear |
| line_state | input | 2 | Sampled line: 01 J, 10 K, 00 idle |
| xact_busy | input | 1 | A transaction is in progress |
| pwr_o | output | 1 | Port power |
| ena_o | output | 1 | Port enable |
| susp_o | output | 1 | Suspend status |
| fres_o | output | 1 | Resume in progress |
| prst_o | output | 1 | Reset in progress |
| chg_o | output | 1 | Sticky port change flag |
| port_state | output | 2 | 00 disabled, 01 enabled, 10 suspended |
| drive_k | output | 1 | Drive resume K signaling |
| drive_se0 | output | 1 | Drive bus reset signaling |
| tx_allow | output | 1 | Downstream traffic permitted |

## Verification
A miscounting timer appears at the ports as a `prst_o` or `fres_o` pulse of the wrong length, so it shows within one sequence. A lost pending suspend leaves `susp_o` at 0 in the cycle after `xact_busy` falls. A wrong wakeup decode shows one cycle after the K sample, either as a missing `fres_o`/`chg_o` or as a spurious one on a port that is not suspended. Bits left uncleared after power-off or after resume show on the very next cycle.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
  typedef enum logic [1:0] {
    PS_OFF   = 2'b00,
    PS_ON    = 2'b01,
    PS_SLEEP = 2'b10
  } pstate_e;

  localparam int WR_W  = 6;
  localparam int F_PWR = 0;
  localparam int F_ENA = 1;
  localparam int F_SUS = 2;
  localparam int F_RES = 3;
  localparam int F_RST = 4;
  localparam int F_CHG = 5;

  localparam logic [1:0] LINE_J = 2'b01;
  localparam logic [1:0] LINE_K = 2'b10;

  function automatic pstate_e state_of(input logic live, input logic susp);
    if (!live) return PS_OFF;
    else if (susp) return PS_SLEEP;
    else return PS_ON;
  endfunction

  function automatic logic j_to_k(input logic [1:0] prev, input logic [1:0] cur);
    return (prev == LINE_J) && (cur == LINE_K);
  endfunction
endpackage

// File: rtl/usbp_seq_timer.sv
module usbp_seq_timer #(
  parameter int DUR = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  output logic done
);
  localparam int CW = $clog2(DUR + 1);
  localparam logic [CW-1:0] LOAD = CW'(DUR - 1);

  logic [CW-1:0] cnt;

  assign done = active && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (start) cnt <= LOAD;
    else if (active && cnt != '0) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/usbp_linewake.sv
module usbp_linewake (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] line_state,
  output logic       jk_edge
);
  import usbp_pkg::*;

  logic [1:0] prev_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_line <= 2'b00;
    else prev_line <= line_state;
  end

  assign jk_edge = j_to_k(prev_line, line_state);
endmodule

// File: rtl/usbp_port_regs.sv
module usbp_port_regs (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [usbp_pkg::WR_W-1:0] wr_data,
  input  logic                      xact_busy,
  input  logic                      jk_edge,
  input  logic                      rst_done,
  input  logic                      res_done,
  output logic                      pwr,
  output logic                      ena,
  output logic                      susp,
  output logic                      fres,
  output logic                      prst,
  output logic                      chg,
  output logic                      wake_take,
  output logic                      rst_start,
  output logic                      res_start
);
  import usbp_pkg::*;

  logic pend;
  logic pwr_n, ena_n, fres_req, susp_req;
  logic prst_d, susp_d, fres_d, pend_d, chg_d;

  always_comb begin
    pwr_n     = wr_en ? wr_data[F_PWR] : pwr;
    ena_n     = wr_en ? wr_data[F_ENA] : ena;
    rst_start = wr_en && wr_data[F_RST] && pwr_n && !prst;
    wake_take = jk_edge && ena && susp && !fres && pwr_n && !rst_start;
    fres_req  = wr_en && wr_data[F_RES] && ena_n && !prst;
    res_start = pwr_n && !rst_start && !fres && (wake_take || fres_req);
    susp_req  = wr_en && wr_data[F_SUS] && ena_n && !prst && !fres && !susp && !pend;

    prst_d = prst;
    susp_d = susp;
    fres_d = fres;
    pend_d = pend;

    if (!pwr_n) begin
      prst_d = 1'b0;
      susp_d = 1'b0;
      fres_d = 1'b0;
      pend_d = 1'b0;
    end else if (rst_start) begin
      prst_d = 1'b1;
      susp_d = 1'b0;
      fres_d = 1'b0;
      pend_d = 1'b0;
    end else begin
      if (prst && rst_done) prst_d = 1'b0;
      if (fres && res_done) begin
        fres_d = 1'b0;
        susp_d = 1'b0;
        pend_d = 1'b0;
      end else begin
        if (res_start) fres_d = 1'b1;
        if (!ena_n) pend_d = 1'b0;
        else if (pend && !xact_busy) begin
          susp_d = 1'b1;
          pend_d = 1'b0;
        end else if (susp_req) begin
          if (xact_busy) pend_d = 1'b1;
          else susp_d = 1'b1;
        end
      end
    end

    if (wake_take) chg_d = 1'b1;
    else if (wr_en && wr_data[F_CHG]) chg_d = 1'b0;
    else chg_d = chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr  <= 1'b0;
      ena  <= 1'b0;
      susp <= 1'b0;
      fres <= 1'b0;
      prst <= 1'b0;
      pend <= 1'b0;
      chg  <= 1'b0;
    end else begin
      pwr  <= pwr_n;
      ena  <= ena_n;
      susp <= susp_d;
      fres <= fres_d;
      prst <= prst_d;
      pend <= pend_d;
      chg  <= chg_d;
    end
  end
endmodule

// File: rtl/usbp_port_ctrl.sv
module usbp_port_ctrl #(
  parameter int RESET_CYC  = 12,
  parameter int RESUME_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [5:0] wr_data,
  input  logic [1:0] line_state,
  input  logic       xact_busy,
  output logic       pwr_o,
  output logic       ena_o,
  output logic       susp_o,
  output logic       fres_o,
  output logic       prst_o,
  output logic       chg_o,
  output logic [1:0] port_state,
  output logic       drive_k,
  output logic       drive_se0,
  output logic       tx_allow
);
  import usbp_pkg::*;

  logic jk_edge, rst_done, res_done, wake_take, rst_start, res_start;
  pstate_e st;

  usbp_linewake u_wake (
    .clk(clk), .rst_n(rst_n), .line_state(line_state), .jk_edge(jk_edge)
  );

  usbp_seq_timer #(.DUR(RESET_CYC)) u_rst_tmr (
    .clk(clk), .rst_n(rst_n), .start(rst_start), .active(prst_o), .done(rst_done)
  );

  usbp_seq_timer #(.DUR(RESUME_CYC)) u_res_tmr (
    .clk(clk), .rst_n(rst_n), .start(res_start), .active(fres_o), .done(res_done)
  );

  usbp_port_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .xact_busy(xact_busy), .jk_edge(jk_edge), .rst_done(rst_done),
    .res_done(res_done), .pwr(pwr_o), .ena(ena_o), .susp(susp_o),
    .fres(fres_o), .prst(prst_o), .chg(chg_o), .wake_take(wake_take),
    .rst_start(rst_start), .res_start(res_start)
  );

  assign st         = state_of(pwr_o && ena_o, susp_o);
  assign port_state = st;
  assign drive_k    = fres_o;
  assign drive_se0  = prst_o;
  assign tx_allow   = (st == PS_ON) && !prst_o;
endmodule

// File: rtl/usbp_port_ctrl_chk.sv
module usbp_port_ctrl_chk #(
  parameter int RESET_CYC = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [5:0] wr_data,
  input logic       xact_busy,
  input logic       pwr_o,
  input logic       susp_o,
  input logic       fres_o,
  input logic       prst_o,
  input logic       chg_o,
  input logic [1:0] port_state,
  input logic       tx_allow,
  input logic       wake_take
);
  localparam int RW = $clog2(RESET_CYC + 1) + 1;
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else if (prst_o) run <= run + 1'b1;
    else run <= '0;
  end

  assert_prst_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prst_o |-> (run < RW'(RESET_CYC)));
  assert_prst_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prst_o) |-> $past(wr_en && wr_data[4]));
  assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    port_state != 2'b11);
  assert_tx_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_allow |-> (port_state == 2'b01 && !prst_o));
  assert_susp_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_o) |-> !$past(xact_busy));
  assert_no_susp_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[1]) |=> !$rose(susp_o));
  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_take |=> (fres_o && chg_o));
  assert_resume_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fres_o) |-> !susp_o);
  assert_chg_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_o) |-> $past(wake_take));
  assert_unpowered_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_o |-> (!prst_o && !susp_o && !fres_o));
endmodule

bind usbp_port_ctrl usbp_port_ctrl_chk #(.RESET_CYC(RESET_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .xact_busy(xact_busy), .pwr_o(pwr_o), .susp_o(susp_o), .fres_o(fres_o),
  .prst_o(prst_o), .chg_o(chg_o), .port_state(port_state),
  .tx_allow(tx_allow), .wake_take(wake_take)
);

// File: tb/tb_usbp_port_ctrl.sv
`timescale 1ns/1ps
module tb_usbp_port_ctrl;
  localparam int RST = 12;
  localparam int RES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic [1:0] line_state = 2'b00;
  logic xact_busy = 1'b0;
  logic pwr_o, ena_o, susp_o, fres_o, prst_o, chg_o, drive_k, drive_se0, tx_allow;
  logic [1:0] port_state;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  usbp_port_ctrl #(.RESET_CYC(RST), .RESUME_CYC(RES)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .line_state(line_state), .xact_busy(xact_busy), .pwr_o(pwr_o),
    .ena_o(ena_o), .susp_o(susp_o), .fres_o(fres_o), .prst_o(prst_o),
    .chg_o(chg_o), .port_state(port_state), .drive_k(drive_k),
    .drive_se0(drive_se0), .tx_allow(tx_allow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  function automatic int exp_state(input logic p, input logic e, input logic s);
    if (!(p && e)) return 0;
    return s ? 2 : 1;
  endfunction

  task automatic t_reset_state();
    check("R1 port_state", port_state, 0);
    check("R1 outputs", {pwr_o, ena_o, susp_o, fres_o, prst_o, chg_o, drive_k, drive_se0, tx_allow}, 0);
  endtask

  task automatic t_enable();
    wr(6'b000011);
    check("R3 enabled state", port_state, exp_state(1, 1, 0));
    check("R3 tx_allow on", tx_allow, 1);
    wr(6'b000001);
    check("R3 disabled state", port_state, 0);
    check("R3 tx_allow off", tx_allow, 0);
    wr(6'b000011);
  endtask

  task automatic t_port_reset();
    int n = 0;
    wr(6'b010011);
    check("R3 tx blocked in reset", tx_allow, 0);
    check("R2 se0 driven", drive_se0, 1);
    while (prst_o && n < 100) begin n++; @(negedge clk); end
    check("R2 reset length", n, RST);
    check("R2 se0 released", drive_se0, 0);
  endtask

  task automatic t_susp_idle();
    wr(6'b000111);
    check("R4 suspend idle", susp_o, 1);
    check("R3 suspended state", port_state, 2);
    check("R3 tx blocked suspended", tx_allow, 0);
  endtask

  task automatic t_ignore_zero();
    wr(6'b000011);
    repeat (2) @(negedge clk);
    check("R5 susp keeps", susp_o, 1);
    check("R5 fres keeps", fres_o, 0);
  endtask

  task automatic t_wake();
    int n = 0;
    line_state = 2'b01;
    repeat (2) @(negedge clk);
    line_state = 2'b10;
    @(negedge clk);
    line_state = 2'b00;
    check("R7 wake fres", fres_o, 1);
    check("R7 wake chg", chg_o, 1);
    while (fres_o && n < 100) begin n++; @(negedge clk); end
    check("R8 wake resume length", n, RES);
    check("R8 susp cleared after resume", susp_o, 0);
    check("R9 chg sticky", chg_o, 1);
  endtask

  task automatic t_chg_clear();
    wr(6'b100011);
    check("R9 chg cleared", chg_o, 0);
  endtask

  task automatic t_wake_not_susp();
    line_state = 2'b01;
    repeat (2) @(negedge clk);
    line_state = 2'b10;
    @(negedge clk);
    line_state = 2'b00;
    @(negedge clk);
    check("R7 no wake when enabled", fres_o, 0);
    check("R7 no chg when enabled", chg_o, 0);
  endtask

  task automatic t_sw_resume();
    int n = 0;
    wr(6'b000111);
    wr(6'b001011);
    check("R8 drive_k", drive_k, 1);
    while (fres_o && n < 100) begin n++; @(negedge clk); end
    check("R8 sw resume length", n, RES);
    check("R8 susp cleared", susp_o, 0);
    check("R8 state back to enabled", port_state, 1);
  endtask

  task automatic t_busy_suspend();
    xact_busy = 1'b1;
    wr(6'b000111);
    repeat (3) begin
      check("R4 held while busy", susp_o, 0);
      @(negedge clk);
    end
    xact_busy = 1'b0;
    @(negedge clk);
    check("R4 suspend after busy", susp_o, 1);
  endtask

  task automatic t_reset_in_suspend();
    wr(6'b010011);
    check("R2 reset in suspend", prst_o, 1);
    check("R2 reset clears suspend", susp_o, 0);
    repeat (RST + 2) @(negedge clk);
    check("R2 reset done", prst_o, 0);
  endtask

  task automatic t_disabled_susp();
    wr(6'b000001);
    wr(6'b000101);
    @(negedge clk);
    check("R6 susp unchanged", susp_o, 0);
    check("R6 state disabled", port_state, 0);
    wr(6'b000011);
    check("R6 enabled not suspended", port_state, 1);
  endtask

  task automatic t_power_off();
    wr(6'b000111);
    check("R10 pre suspended", susp_o, 1);
    wr(6'b000000);
    check("R10 susp cleared", susp_o, 0);
    wr(6'b011110);
    check("R10 no reset unpowered", prst_o, 0);
    check("R10 no resume unpowered", fres_o, 0);
    check("R10 no suspend unpowered", susp_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_enable();
    t_port_reset();
    t_susp_idle();
    t_ignore_zero();
    t_wake();
    t_chg_clear();
    t_wake_not_susp();
    t_sw_resume();
    t_busy_suspend();
    t_reset_in_suspend();
    t_disabled_susp();
    t_power_off();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule